// File: doc/BRIEF.md
# GPIO Control Register Block

This block is a bank of 16-bit control registers sitting on a simple synchronous memory-mapped bus. It holds storage for a mode word, a clock divider, a clock control word, a power word, and three interrupt words (request, mask, status). It also holds a read-only status word and a 16-line general-purpose I/O unit. The interrupt words are plain storage only. Nothing in this block raises an interrupt from them.

The GPIO unit keeps a direction register, where a 1 makes the pin an output, and a level register. The output lines carry the level ANDed with the direction. They are registered and are refreshed only when software writes the direction or the level. External pins can strobe individual level bits. These pin updates bypass the direction mask and leave the outputs untouched until the next refresh.

Reads are combinational from the registered state. Writes take effect on the rising edge where select and write-enable are both high. An access to an offset that maps to nothing produces a one-cycle flag on the following cycle.

Top module: `gpreg_top`

## Requirements
- R1: Only address bits [5:0] select a register, so addresses that differ only above bit 5 reach the same register.
- R2: Only the low 16 bits of write data are stored. Bits above 15 are dropped.
- R3: A write to offset 0x0C stores the value. When bit 7 of that value is 1, bits 15 and 6 are also set (value OR 0x8040).
- R4: Offset 0x08 always reads 0x0002, and writes to it change nothing.
- R5: Offsets 0x24 and 0x28 both read the level register. A write to either stores the written value ANDed with the direction register.
- R6: Offset 0x20 reads and writes the 16-bit direction register, where bit n = 1 makes pin n an output.
- R7: On the same edge as a write to offset 0x20, 0x24 or 0x28, `gpio_out` becomes the new level AND the new direction.
- R8: A cycle with `pin_stb[n]` high copies `pin_val[n]` into level bit n with no direction masking. `gpio_out` stays unchanged until the next write named in R7.
- R9: Offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C are independent read/write 16-bit storage registers.
- R10: Any offset not listed in R3 to R9 reads 0 and ignores writes. One cycle after a selected access to such an offset, `bad_acc` is 1; after any other cycle it is 0.
- R11: After reset every register reads 0 except offset 0x08, and `gpio_out` is 0.
- R12: When a bus write to the level register and a pin strobe happen in the same cycle, the bus value (masked by direction) wins for every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [5:0] decode |
| bus_wdata | input | DATA_W | Write data; low 16 bits stored |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| bad_acc | output | 1 | Pulses high the cycle after an unmapped access |
| pin_stb | input | 16 | Per-pin strobe: load level bit from pin_val |
| pin_val | input | 16 | Pin values sampled where pin_stb is high |
| gpio_out | output | 16 | Registered output lines, level AND direction |

## Verification
The bench builds the block with its default 12-bit address and 32-bit data bus. This means address bits above bit 5 and data bits above bit 15 really exist and can be driven. That makes the aliasing of high addresses onto the same register, and the silent dropping of the upper data half, observable at the ports. The bench also drives pin strobes and bus writes in the same cycle, so the priority between them shows up in the read-back level.

// File: rtl/gpreg_pkg.sv
package gpreg_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int REG_W  = 16;
    localparam int NPIN   = REG_W;
    localparam int OFF_W  = 6;
    localparam int NPLAIN = 6;

    localparam logic [REG_W-1:0] STAT_RESET = 16'h0002;
    localparam int               PWR_TRIG   = 7;
    localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;

    typedef enum logic [3:0] {
        SEL_MODE, SEL_CDIV, SEL_STAT, SEL_PWR, SEL_CCTL, SEL_IREQ,
        SEL_IMSK, SEL_ISTS, SEL_DIR, SEL_LVL, SEL_NONE
    } regsel_e;

    typedef struct packed {
        logic             en;
        regsel_e          target;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic regsel_e decode_off(input logic [OFF_W-1:0] off);
        case (off)
            6'h00:        return SEL_MODE;
            6'h04:        return SEL_CDIV;
            6'h08:        return SEL_STAT;
            6'h0C:        return SEL_PWR;
            6'h10:        return SEL_CCTL;
            6'h14:        return SEL_IREQ;
            6'h18:        return SEL_IMSK;
            6'h1C:        return SEL_ISTS;
            6'h20:        return SEL_DIR;
            6'h24, 6'h28: return SEL_LVL;
            default:      return SEL_NONE;
        endcase
    endfunction

    // storage slot g of the plain register array
    function automatic regsel_e plain_target(input int slot);
        case (slot)
            0:       return SEL_MODE;
            1:       return SEL_CDIV;
            2:       return SEL_CCTL;
            3:       return SEL_IREQ;
            4:       return SEL_IMSK;
            default: return SEL_ISTS;
        endcase
    endfunction
endpackage

// File: rtl/gpreg_decode.sv
module gpreg_decode
    import gpreg_pkg::*;
(
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [OFF_W-1:0] off,
    input  logic [REG_W-1:0] wdata,
    output regsel_e          rsel,
    output wr_req_t          wreq,
    output logic             bad
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        rsel        = decode_off(off);
        wreq.en     = bus_sel && bus_we && (rsel != SEL_NONE);
        wreq.target = rsel;
        wreq.data   = wdata;
        bad         = bus_sel && (rsel == SEL_NONE);
    end
endmodule

// File: rtl/gpreg_store.sv
module gpreg_store
    import gpreg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  wr_req_t                      wreq,
    output logic [NPLAIN-1:0][REG_W-1:0] plain_q,
    output logic [REG_W-1:0]             pwr_q,
    output logic [REG_W-1:0]             stat_q
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst)
                plain_q[g] <= '0;
            else if (wreq.en && wreq.target == plain_target(g))
                plain_q[g] <= wreq.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pwr_q <= '0;
        else if (wreq.en && wreq.target == SEL_PWR)
            pwr_q <= wreq.data | (wreq.data[PWR_TRIG] ? PWR_FORCE : '0);
    end

    // read-only word: only reset loads it
    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= STAT_RESET;
    end
endmodule

// File: rtl/gpreg_gpio.sv
module gpreg_gpio
    import gpreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_req_t         wreq,
    input  logic [NPIN-1:0] pin_stb,
    input  logic [NPIN-1:0] pin_val,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] lvl_q,
    output logic [NPIN-1:0] out_q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic            dir_wr, lvl_wr, refresh;
    logic [NPIN-1:0] dir_next, lvl_next;

    always_comb begin
        dir_wr   = wreq.en && wreq.target == SEL_DIR;
        lvl_wr   = wreq.en && wreq.target == SEL_LVL;
        refresh  = dir_wr || lvl_wr;
        dir_next = dir_wr ? wreq.data : dir_q;
        // pins load unmasked; a bus level write overrides all bits
        lvl_next = (lvl_q & ~pin_stb) | (pin_val & pin_stb);
        if (lvl_wr)
            lvl_next = wreq.data & dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lvl_q <= '0;
            out_q <= '0;
        end else begin
            dir_q <= dir_next;
            lvl_q <= lvl_next;
            if (refresh)
                out_q <= lvl_next & dir_next;
        end
    end
endmodule

// File: rtl/gpreg_top.sv
module gpreg_top
    import gpreg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bad_acc,
    input  logic [NPIN-1:0]   pin_stb,
    input  logic [NPIN-1:0]   pin_val,
    output logic [NPIN-1:0]   gpio_out
);
    timeunit 1ns;
    timeprecision 1ps;

    regsel_e                     rsel;
    wr_req_t                     wreq;
    logic                        bad_now;
    logic [NPLAIN-1:0][REG_W-1:0] plain_q;
    logic [REG_W-1:0]            pwr_q, stat_q;
    logic [NPIN-1:0]             dir_q, lvl_q;

    gpreg_decode u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .off     (bus_addr[OFF_W-1:0]),
        .wdata   (bus_wdata[REG_W-1:0]),
        .rsel    (rsel),
        .wreq    (wreq),
        .bad     (bad_now)
    );

    gpreg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wreq    (wreq),
        .plain_q (plain_q),
        .pwr_q   (pwr_q),
        .stat_q  (stat_q)
    );

    gpreg_gpio u_gpio (
        .clk     (clk),
        .rst     (rst),
        .wreq    (wreq),
        .pin_stb (pin_stb),
        .pin_val (pin_val),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .out_q   (gpio_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            SEL_STAT: bus_rdata = stat_q;
            SEL_PWR:  bus_rdata = pwr_q;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_LVL:  bus_rdata = lvl_q;
            SEL_NONE: bus_rdata = '0;
            default: begin
                for (int i = 0; i < NPLAIN; i++)
                    if (rsel == plain_target(i))
                        bus_rdata = plain_q[i];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bad_acc <= 1'b0;
        else
            bad_acc <= bad_now;
    end
endmodule

// File: rtl/gpreg_chk.sv
module gpreg_chk
    import gpreg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              bad_acc,
    input logic [NPIN-1:0]   pin_stb,
    input logic [NPIN-1:0]   pin_val,
    input logic [NPIN-1:0]   gpio_out,
    input logic [NPIN-1:0]   dir_q,
    input logic [NPIN-1:0]   lvl_q,
    input logic [REG_W-1:0]  pwr_q,
    input logic [REG_W-1:0]  mode_q
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-REG_W){1'b0}}, {REG_W{1'b1}}};

    logic [OFF_W-1:0] off;
    logic wr, lvl_wr, cfg_wr, unmapped;

    always_comb begin
        off      = bus_addr[OFF_W-1:0];
        wr       = bus_sel && bus_we;
        lvl_wr   = wr && (off == 6'h24 || off == 6'h28);
        cfg_wr   = lvl_wr || (wr && off == 6'h20);
        unmapped = (off[1:0] != 2'b00) || (off > 6'h28);
    end

    p_alias_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(bus_sel && bus_we) && !$past(|pin_stb) &&
         $stable(bus_addr[OFF_W-1:0]) && !$stable(bus_addr)) |-> $stable(bus_rdata));

    p_trunc_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && off == 6'h00) |=> ({{(DATA_W-REG_W){1'b0}}, mode_q} == $past(bus_wdata & LOW_MASK)));

    p_pwr_force_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && off == 6'h0C && bus_wdata[7]) |=> (pwr_q[15] && pwr_q[6]));

    p_stat_read_r4: assert property (@(posedge clk) disable iff (rst)
        (off == 6'h08) |-> (bus_rdata == 16'h0002));

    p_lvl_mask_r5: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> ((lvl_q & ~$past(dir_q)) == '0));

    p_out_in_dir_r7: assert property (@(posedge clk) disable iff (rst)
        ((gpio_out & ~dir_q) == '0));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(gpio_out));

    p_pin_load_r8: assert property (@(posedge clk) disable iff (rst)
        !lvl_wr |=> (((lvl_q ^ $past(pin_val)) & $past(pin_stb)) == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (bus_rdata == '0));

    p_bad_set_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && unmapped) |=> bad_acc);

    p_bad_clr_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && unmapped) |=> !bad_acc);

    p_bus_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (lvl_wr && (|pin_stb)) |=> (lvl_q == ($past(bus_wdata[REG_W-1:0]) & $past(dir_q))));
endmodule

bind gpreg_top gpreg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bad_acc   (bad_acc),
    .pin_stb   (pin_stb),
    .pin_val   (pin_val),
    .gpio_out  (gpio_out),
    .dir_q     (dir_q),
    .lvl_q     (lvl_q),
    .pwr_q     (pwr_q),
    .mode_q    (plain_q[0])
);

// File: tb/sim_gpreg_top.sv
module sim_gpreg_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [15:0]   bus_rdata;
    logic          bad_acc;
    logic [15:0]   pin_stb, pin_val, gpio_out;

    always #2.5 clk = ~clk;

    gpreg_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bad_acc(bad_acc), .pin_stb(pin_stb), .pin_val(pin_val),
        .gpio_out(gpio_out)
    );

    typedef enum {K_RD, K_OUT, K_BAD} kind_e;
    typedef struct {
        kind_e       kind;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;

    // ---------------- driver ----------------
    task automatic go_idle();
        bus_sel = 1'b0; bus_we = 1'b0; pin_stb = '0;
    endtask

    task automatic push(kind_e k, logic [15:0] e, string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        go_idle();
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr_pin(logic [AW-1:0] a, logic [DW-1:0] d, logic [15:0] m, logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        pin_stb = m; pin_val = v;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [15:0] e, string r);
        @(negedge clk);
        go_idle();
        bus_sel = 1'b1; bus_addr = a;
        push(K_RD, e, r);
    endtask

    task automatic pin(logic [15:0] m, logic [15:0] v);
        @(negedge clk);
        go_idle();
        pin_stb = m; pin_val = v;
    endtask

    task automatic chk_out(logic [15:0] e, string r);
        @(negedge clk);
        go_idle();
        push(K_OUT, e, r);
    endtask

    task automatic chk_bad(logic e, string r);
        @(negedge clk);
        go_idle();
        push(K_BAD, {15'b0, e}, r);
    endtask

    // ---------------- monitor ----------------
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_OUT:   act = gpio_out;
                    default: act = {15'b0, bad_acc};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s %s: actual %h expected %h", it.req, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst = 1'b1; go_idle(); bus_addr = '0; bus_wdata = '0; pin_val = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11 / R4: reset values
        rd(12'h008, 16'h0002, "R4");
        for (int i = 0; i < 11; i++) begin
            if (i != 2) rd(12'(i * 4), 16'h0000, "R11");
        end
        chk_out(16'h0000, "R11");

        // R2: upper data dropped
        wr(12'h000, 32'hABCD_1234);
        rd(12'h000, 16'h1234, "R2");

        // R9: plain storage registers independent
        wr(12'h004, 32'h0000_1101);
        wr(12'h010, 32'h0000_1102);
        wr(12'h014, 32'h0000_1103);
        wr(12'h018, 32'h0000_1104);
        wr(12'h01C, 32'h0000_1105);
        rd(12'h004, 16'h1101, "R9");
        rd(12'h010, 16'h1102, "R9");
        rd(12'h014, 16'h1103, "R9");
        rd(12'h018, 16'h1104, "R9");
        rd(12'h01C, 16'h1105, "R9");
        rd(12'h000, 16'h1234, "R9");

        // R1: high address bits ignored
        rd(12'h040, 16'h1234, "R1");
        wr(12'hFC4, 32'h0000_5A5A);
        rd(12'h004, 16'h5A5A, "R1");

        // R3: power word side effect
        wr(12'h00C, 32'h0000_0080);
        rd(12'h00C, 16'h80C0, "R3");
        wr(12'h00C, 32'h0000_0001);
        rd(12'h00C, 16'h0001, "R3");
        wr(12'h00C, 32'h0001_0081);
        rd(12'h00C, 16'h80C1, "R3");

        // R4: status ignores writes
        wr(12'h008, 32'h0000_FFFF);
        rd(12'h008, 16'h0002, "R4");

        // R6 / R7: direction
        wr(12'h020, 32'hFFFF_00FF);
        rd(12'h020, 16'h00FF, "R6");
        chk_out(16'h0000, "R7");

        // R5 / R7: level aliases and masking
        wr(12'h024, 32'h0000_0F0F);
        chk_out(16'h000F, "R7");
        rd(12'h028, 16'h000F, "R5");
        wr(12'h028, 32'h0000_FFF0);
        rd(12'h024, 16'h00F0, "R5");
        chk_out(16'h00F0, "R7");

        // R8: pins load unmasked, outputs hold
        pin(16'hFF00, 16'hAB00);
        chk_out(16'h00F0, "R8");
        rd(12'h024, 16'hABF0, "R8");
        pin(16'h00F0, 16'h0000);
        chk_out(16'h00F0, "R8");
        rd(12'h028, 16'hAB00, "R8");

        // R7: direction write refreshes outputs
        wr(12'h020, 32'h0000_F000);
        chk_out(16'hA000, "R7");
        rd(12'h024, 16'hAB00, "R6");

        // R10: unmapped offsets
        rd(12'h02C, 16'h0000, "R10");
        chk_bad(1'b1, "R10");
        rd(12'h001, 16'h0000, "R10");
        chk_bad(1'b1, "R10");
        wr(12'h03C, 32'h0000_FFFF);
        chk_bad(1'b1, "R10");
        wr(12'h002, 32'h0000_FFFF);
        rd(12'h000, 16'h1234, "R10");
        rd(12'h004, 16'h5A5A, "R10");
        chk_bad(1'b0, "R10");

        // R12: bus level write beats a same-cycle pin strobe
        wr(12'h020, 32'h0000_0FF0);
        chk_out(16'h0B00, "R7");
        wr_pin(12'h024, 32'h0000_FFFF, 16'h00FF, 16'h00FF);
        rd(12'h024, 16'h0FF0, "R12");
        chk_out(16'h0FF0, "R12");
        pin(16'h000F, 16'h000F);
        rd(12'h024, 16'h0FFF, "R8");
        chk_out(16'h0FF0, "R8");

        @(negedge clk);
        go_idle();
        #2;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule